// File: doc/BRIEF.md
# Branch Target Buffer With Cache-Way Hints

This block is a direct-mapped branch target buffer. Each entry holds the predicted target address and a pointer to the instruction-cache way that holds the target's line. A valid bit guards that pointer. When a branch PC hits in the buffer, the block returns the target and, if the pointer is valid, a way hint. The instruction cache then enables only that way and skips the tag comparison for the fetch at the target. Lookup is combinational, so the hint arrives in the same cycle as the target and adds no latency.

A fresh allocation records the target with the way pointer marked invalid. After the first fetch at the target has done a full probe, the fetch logic reports the way that hit, and the entry stores it. When the cache evicts a line, it reports the set and way it replaced. Every entry whose target falls in that set and whose valid pointer names that way has the pointer dropped. The entry keeps its target prediction.

Top module: `btb_way_hint`

## Requirements
- R1: After reset every lookup misses (`lu_hit`=0) and reports `lu_hint_valid`=0.
- R2: One cycle after an allocation of (`alloc_pc`, `alloc_tgt`), a lookup of `alloc_pc` gives `lu_hit`=1, `lu_tgt`=`alloc_tgt` and `lu_hint_valid`=0.
- R3: Entries are indexed by `pc[IDX_W+1:2]` and tagged with `pc[PC_W-1:IDX_W+2]`. A lookup whose index matches a resident entry but whose tag differs gives `lu_hit`=0 and `lu_hint_valid`=0. `lu_hint_valid` is never 1 without `lu_hit`.
- R4: A way report (`fill_valid`, `fill_pc`, `fill_way`) for a resident PC stores `fill_way`. Later lookups of that PC give `lu_hint_valid`=1 and `lu_hint_way`=`fill_way`.
- R5: An eviction report (`inv_valid`, `inv_set`, `inv_way`) clears the hint valid bit of every entry that meets three conditions: its target bits `[LINE_OFS+SET_W-1:LINE_OFS]` equal `inv_set`, its stored way equals `inv_way`, and its hint was valid. The entry's hit and target are kept.
- R6: An eviction report whose set or way differs from an entry's leaves that entry's hint valid and unchanged.
- R7: When a lookup and a matching eviction report arrive in the same cycle, the eviction wins: that cycle's lookup already gives `lu_hint_valid`=0.
- R8: A way report is ignored when its PC is not resident (tag mismatch or empty entry). It is also ignored when, in the same cycle, an eviction report names the reported way and the set of the entry's target.
- R9: Allocating over a resident entry replaces its target and leaves the hint invalid, even if an earlier hint was valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lu_valid | input | 1 | Lookup request |
| lu_pc | input | PC_W | Branch PC being looked up |
| lu_hit | output | 1 | Resident entry matches lu_pc |
| lu_tgt | output | PC_W | Predicted target |
| lu_hint_valid | output | 1 | lu_hint_way may be used |
| lu_hint_way | output | WAY_W | Cache way holding the target line |
| alloc_valid | input | 1 | Allocate an entry |
| alloc_pc | input | PC_W | Branch PC to allocate |
| alloc_tgt | input | PC_W | Target to record |
| fill_valid | input | 1 | Way report after a full probe |
| fill_pc | input | PC_W | Branch PC whose target was probed |
| fill_way | input | WAY_W | Way that hit |
| inv_valid | input | 1 | Cache line eviction report |
| inv_set | input | SET_W | Set of the evicted line |
| inv_way | input | WAY_W | Way of the evicted line |

## Verification
Two things can coincide in one cycle. An eviction can meet a lookup of the entry it targets, and an eviction can meet a way report for that same entry. The bench provokes the first by driving a matching eviction while the lookup is active. It checks that the hint is already invalid in that cycle and stays invalid afterwards. It provokes the second by issuing a way report together with a matching eviction, and judges the result from a later lookup, which must show no valid hint. Neighbouring entries that do not match are read back to confirm they are untouched.

// File: rtl/btb_way_hint.sv
module btb_way_hint #(
  parameter int PC_W     = 32,
  parameter int ENTRIES  = 64,
  parameter int WAYS     = 4,
  parameter int SET_W    = 6,
  parameter int LINE_OFS = 4,
  parameter int IDX_W    = $clog2(ENTRIES),
  parameter int WAY_W    = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lu_valid,
  input  logic [PC_W-1:0]  lu_pc,
  output logic             lu_hit,
  output logic [PC_W-1:0]  lu_tgt,
  output logic             lu_hint_valid,
  output logic [WAY_W-1:0] lu_hint_way,
  input  logic             alloc_valid,
  input  logic [PC_W-1:0]  alloc_pc,
  input  logic [PC_W-1:0]  alloc_tgt,
  input  logic             fill_valid,
  input  logic [PC_W-1:0]  fill_pc,
  input  logic [WAY_W-1:0] fill_way,
  input  logic             inv_valid,
  input  logic [SET_W-1:0] inv_set,
  input  logic [WAY_W-1:0] inv_way
);
  localparam int TAG_W = PC_W - IDX_W - 2;

  logic [TAG_W-1:0] tag_q [ENTRIES];
  logic [PC_W-1:0]  tgt_q [ENTRIES];
  logic [WAY_W-1:0] way_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q, wv_q;

  wire [IDX_W-1:0] lu_i    = lu_pc[IDX_W+1:2];
  wire [IDX_W-1:0] fill_i  = fill_pc[IDX_W+1:2];
  wire [IDX_W-1:0] alloc_i = alloc_pc[IDX_W+1:2];

  wire lu_inv = inv_valid && tgt_q[lu_i][LINE_OFS +: SET_W] == inv_set
                && way_q[lu_i] == inv_way;

  assign lu_hit        = lu_valid && vld_q[lu_i] && tag_q[lu_i] == lu_pc[PC_W-1:IDX_W+2];
  assign lu_tgt        = tgt_q[lu_i];
  assign lu_hint_way   = way_q[lu_i];
  assign lu_hint_valid = lu_hit && wv_q[lu_i] && !lu_inv;

  wire fill_res  = fill_valid && vld_q[fill_i] && tag_q[fill_i] == fill_pc[PC_W-1:IDX_W+2];
  wire fill_kill = inv_valid && tgt_q[fill_i][LINE_OFS +: SET_W] == inv_set
                   && fill_way == inv_way;
  wire fill_ok   = fill_res && !fill_kill;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      wv_q  <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++)
        if (inv_valid && wv_q[e] && tgt_q[e][LINE_OFS +: SET_W] == inv_set
            && way_q[e] == inv_way)
          wv_q[e] <= 1'b0;
      if (fill_ok) wv_q[fill_i] <= 1'b1;
      if (alloc_valid) begin
        vld_q[alloc_i] <= 1'b1;
        wv_q[alloc_i]  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_ok) way_q[fill_i] <= fill_way;
    if (alloc_valid) begin
      tag_q[alloc_i] <= alloc_pc[PC_W-1:IDX_W+2];
      tgt_q[alloc_i] <= alloc_tgt;
    end
  end
endmodule

// File: rtl/btb_way_hint_chk.sv
module btb_way_hint_chk #(
  parameter int PC_W     = 32,
  parameter int SET_W    = 6,
  parameter int LINE_OFS = 4,
  parameter int WAY_W    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lu_valid,
  input logic [PC_W-1:0]  lu_pc,
  input logic             lu_hit,
  input logic [PC_W-1:0]  lu_tgt,
  input logic             lu_hint_valid,
  input logic [WAY_W-1:0] lu_hint_way,
  input logic             alloc_valid,
  input logic [PC_W-1:0]  alloc_pc,
  input logic [PC_W-1:0]  alloc_tgt,
  input logic             fill_valid,
  input logic [PC_W-1:0]  fill_pc,
  input logic [WAY_W-1:0] fill_way,
  input logic             inv_valid,
  input logic [SET_W-1:0] inv_set,
  input logic [WAY_W-1:0] inv_way
);
  a_r3_hint_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lu_hint_valid |-> lu_hit);

  a_r2_alloc_then_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(alloc_valid) && lu_valid && lu_pc == $past(alloc_pc))
    |-> (lu_hit && !lu_hint_valid && lu_tgt == $past(alloc_tgt)));

  a_r7_inv_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && lu_hit && lu_hint_way == inv_way
     && lu_tgt[LINE_OFS +: SET_W] == inv_set) |-> !lu_hint_valid);

  a_r5_inv_then_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inv_valid && lu_hit && lu_hint_way == inv_way
           && lu_tgt[LINE_OFS +: SET_W] == inv_set && !fill_valid && !alloc_valid)
     && lu_valid && lu_pc == $past(lu_pc)) |-> !lu_hint_valid);
endmodule

bind btb_way_hint btb_way_hint_chk #(
  .PC_W(PC_W), .SET_W(SET_W), .LINE_OFS(LINE_OFS), .WAY_W(WAY_W)
) u_chk (.*);

// File: tb/btb_way_hint_test.sv
`timescale 1ns/1ps
module btb_way_hint_test;
  localparam int N = 64;
  logic clk = 0, rst_n = 0;
  logic lu_valid = 0, alloc_valid = 0, fill_valid = 0, inv_valid = 0;
  logic [31:0] lu_pc = 0, alloc_pc = 0, alloc_tgt = 0, fill_pc = 0, lu_tgt;
  logic [1:0] fill_way = 0, inv_way = 0, lu_hint_way;
  logic [5:0] inv_set = 0;
  logic lu_hit, lu_hint_valid;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  btb_way_hint uut (.*);

  function automatic logic [31:0] pc_of(int i, int t); return (t << 8) | (i << 2); endfunction
  function automatic logic [5:0]  set_of(int i); return 6'((i * 5 + 3) % 64); endfunction
  function automatic logic [31:0] tgt_of(int i, int g); return 32'h0040_0000 | (g << 20) | (i << 12) | (set_of(i) << 4); endfunction
  function automatic logic [1:0]  way_of(int i); return 2'(i % 4); endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
    lu_valid = 0; alloc_valid = 0; fill_valid = 0; inv_valid = 0;
  endtask

  task automatic look(logic [31:0] pc);
    lu_valid = 1; lu_pc = pc; #1;
  endtask

  task automatic done;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    done();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: empty after reset
    for (int i = 0; i < N; i++) begin
      look(pc_of(i, 1));
      chk("R1 hit", lu_hit, 0); chk("R1 hint", lu_hint_valid, 0);
    end
    // R2: allocate every entry
    for (int i = 0; i < N; i++) begin
      alloc_valid = 1; alloc_pc = pc_of(i, 1); alloc_tgt = tgt_of(i, 0); tick();
    end
    for (int i = 0; i < N; i++) begin
      look(pc_of(i, 1));
      chk("R2 hit", lu_hit, 1); chk("R2 tgt", lu_tgt, tgt_of(i, 0));
      chk("R2 hint", lu_hint_valid, 0);
      look(pc_of(i, 2));
      chk("R3 alias hit", lu_hit, 0); chk("R3 alias hint", lu_hint_valid, 0);
    end
    // R8: way report for a non-resident PC is ignored
    for (int i = 0; i < N; i++) begin
      fill_valid = 1; fill_pc = pc_of(i, 2); fill_way = way_of(i); tick();
      look(pc_of(i, 1)); chk("R8 nonresident", lu_hint_valid, 0);
    end
    // R4: way reports
    for (int i = 0; i < N; i++) begin
      fill_valid = 1; fill_pc = pc_of(i, 1); fill_way = way_of(i); tick();
    end
    for (int i = 0; i < N; i++) begin
      look(pc_of(i, 1));
      chk("R4 hint", lu_hint_valid, 1); chk("R4 way", lu_hint_way, way_of(i));
    end
    // R6: wrong way / wrong set evictions
    for (int i = 0; i < N; i++) begin
      inv_valid = 1; inv_set = set_of(i); inv_way = way_of(i) + 2'd1; tick();
      inv_valid = 1; inv_set = set_of(i) + 6'd1; inv_way = way_of(i) + 2'd2; tick();
    end
    for (int i = 0; i < N; i++) begin
      look(pc_of(i, 1)); chk("R6 kept", lu_hint_valid, 1);
    end
    // R7 and R5: eviction meets lookup on even entries
    for (int i = 0; i < N; i += 2) begin
      inv_valid = 1; inv_set = set_of(i); inv_way = way_of(i);
      look(pc_of(i, 1)); chk("R7 same cycle", lu_hint_valid, 0);
      tick();
      look(pc_of(i, 1));
      chk("R5 cleared", lu_hint_valid, 0); chk("R5 hit kept", lu_hit, 1);
      chk("R5 tgt kept", lu_tgt, tgt_of(i, 0));
    end
    for (int i = 1; i < N; i += 2) begin
      look(pc_of(i, 1)); chk("R6 neighbour", lu_hint_valid, 1);
    end
    // R8: way report meets matching eviction
    for (int i = 0; i < N; i += 2) begin
      fill_valid = 1; fill_pc = pc_of(i, 1); fill_way = way_of(i);
      inv_valid = 1; inv_set = set_of(i); inv_way = way_of(i); tick();
      look(pc_of(i, 1)); chk("R8 killed", lu_hint_valid, 0);
      fill_valid = 1; fill_pc = pc_of(i, 1); fill_way = way_of(i) ^ 2'd3; tick();
      look(pc_of(i, 1));
      chk("R4 refill", lu_hint_valid, 1); chk("R4 refill way", lu_hint_way, way_of(i) ^ 2'd3);
    end
    // R9: reallocate over entries with valid hints
    for (int i = 0; i < N; i++) begin
      alloc_valid = 1; alloc_pc = pc_of(i, 3); alloc_tgt = tgt_of(i, 1); tick();
      look(pc_of(i, 3));
      chk("R9 hit", lu_hit, 1); chk("R9 tgt", lu_tgt, tgt_of(i, 1));
      chk("R9 hint", lu_hint_valid, 0);
      look(pc_of(i, 1)); chk("R9 old gone", lu_hit, 0);
    end
    lu_valid = 0;
    tick();
    done();
  end
endmodule